// File: doc/BRIEF.md
# Host Reply Packet Transmitter

This block turns two kinds of reply request into byte packets on a stream toward a host-side FIFO bridge. A capability reply describes the attached display. It carries an eight-character ASCII tag, the width and height in pixels, a brightness-level code and a packed mode byte. These values come from static configuration inputs. A frame report carries a different eight-character tag and the 16-bit number of the frame most recently shown. A command decoder raises `caps_req_i` and a scan controller raises `frame_req_i`, each as a single-cycle pulse. The block then emits the matching packet.

Requests are held in pending flags until their packet has gone out completely. At most one packet is on the stream at a time. Once a packet has started, it runs to its last byte before anything else is chosen. When both packets are waiting, the frame report is chosen first. The field values are captured when a packet starts, so a packet never mixes old and new values.

Back-pressure rules on the output stream:
- A byte is transferred on every rising clock edge at which `tx_valid_o` and `tx_ready_i` are both high.
- While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value.
- `tx_ready_i` may be held high or toggled freely, including while the block is idle.

Top module: `host_reply_tx`

## Requirements
- R1: After reset, and whenever no request is pending, `tx_valid_o` is low.
- R2: A capability reply is 14 bytes long. Bytes 0 to 7 are the ASCII tag 0x44 0x49 0x53 0x50 0x5F 0x53 0x45 0x54.
- R3: In a capability reply, bytes 8 and 9 are the width (low byte, then high byte), and bytes 10 and 11 are the height (low byte, then high byte).
- R4: In a capability reply, byte 12 equals `levels_m1_i`. Byte 13 is {`frames_m1_i` in bits 7:4, 2'b00 in bits 3:2, `channels_i` in bits 1:0}.
- R5: A frame report is 10 bytes long. Bytes 0 to 7 are 0x44 0x49 0x53 0x50 0x5F 0x46 0x52 0x4D, and bytes 8 and 9 are `frame_num_i`, low byte first.
- R6: A request pulse stays pending until its packet has been fully sent. Further pulses of the same kind that arrive while it is pending or being sent produce no additional packet.
- R7: If both requests are pending when the block is idle, the frame report is sent first and the capability reply follows.
- R8: A started packet completes without interruption. A request that arrives meanwhile waits until the packet's last byte has been accepted.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_valid_o` remain unchanged on the next cycle.
- R10: Field inputs are captured on the cycle the packet starts. Later changes do not affect that packet's bytes.
- R11: Only the channel counts 1 and 3 are legal. Both are sent as given in byte 13.
- R12: From idle, a request pulse sampled at clock edge n raises `tx_valid_o` after clock edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| caps_req_i | input | 1 | Pulse requesting a capability reply |
| frame_req_i | input | 1 | Pulse requesting a frame report |
| width_i | input | 16 | Display width in pixels |
| height_i | input | 16 | Display height in pixels |
| levels_m1_i | input | 8 | Brightness levels minus one |
| frames_m1_i | input | 4 | Frame-buffer count minus one |
| channels_i | input | 2 | Colour channel count (1 or 3) |
| frame_num_i | input | 16 | Number of the frame last shown |
| tx_data_o | output | 8 | Output stream byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Downstream ready to accept |

## Verification
The assertions check the cycle-level rules on every cycle:
- bytes are held under back-pressure;
- the packet kind does not change while a packet is in flight;
- the byte index stays within the packet length;
- the frame report wins when both requests are pending;
- a request pulse always lands in a pending flag;
- the channel code is legal when a capability reply starts.

Only the bench scenarios can show the following:
- the actual byte contents and their little-endian order;
- the merging of repeated pulses into one packet;
- the capture of fields at packet start;
- the order in which whole packets appear when requests overlap.

// File: rtl/host_reply_pkg.sv
package host_reply_pkg;
  localparam int BYTE_W   = 8;
  localparam int DIM_W    = 16;
  localparam int FNUM_W   = 16;
  localparam int LVL_W    = 8;
  localparam int FBUF_W   = 4;
  localparam int CHAN_W   = 2;
  localparam int TAG_LEN  = 8;
  localparam int CAPS_LEN = TAG_LEN + 2 * (DIM_W / BYTE_W) + 2;
  localparam int FRM_LEN  = TAG_LEN + FNUM_W / BYTE_W;
  localparam int MAX_LEN  = (CAPS_LEN > FRM_LEN) ? CAPS_LEN : FRM_LEN;
  localparam int IDX_W    = $clog2(MAX_LEN);
  localparam int N_KIND   = 2;

  // index order is also arbitration priority: lower index wins
  typedef enum logic [0:0] {
    KIND_FRAME = 1'b0,
    KIND_CAPS  = 1'b1
  } reply_kind_e;

  typedef struct packed {
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
    logic [LVL_W-1:0]  levels;
    logic [BYTE_W-1:0] mode;
    logic [FNUM_W-1:0] fnum;
  } reply_fields_t;

  function automatic logic [BYTE_W-1:0] tag_byte(reply_kind_e k, logic [2:0] i);
    logic [BYTE_W-1:0] b;
    case (i)
      3'd0: b = 8'h44;
      3'd1: b = 8'h49;
      3'd2: b = 8'h53;
      3'd3: b = 8'h50;
      3'd4: b = 8'h5F;
      3'd5: b = (k == KIND_CAPS) ? 8'h53 : 8'h46;
      3'd6: b = (k == KIND_CAPS) ? 8'h45 : 8'h52;
      default: b = (k == KIND_CAPS) ? 8'h54 : 8'h4D;
    endcase
    return b;
  endfunction

  function automatic logic [IDX_W-1:0] last_index(reply_kind_e k);
    return (k == KIND_CAPS) ? IDX_W'(CAPS_LEN - 1) : IDX_W'(FRM_LEN - 1);
  endfunction
endpackage

// File: rtl/reply_req_latch.sv
module reply_req_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)         pend_o[k] <= 1'b0;
        else if (clr_i[k])  pend_o[k] <= 1'b0;  // completion wins: merged pulse is absorbed
        else if (set_i[k])  pend_o[k] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/reply_arbiter.sv
module reply_arbiter #(
  parameter int N  = 2,
  localparam int GW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [GW-1:0] grant_o
);
  always_comb begin
    grant_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) grant_o = GW'(k);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/reply_byte_gen.sv
module reply_byte_gen
  import host_reply_pkg::*;
(
  input  reply_kind_e        kind_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  reply_fields_t      fld_i,
  output logic [BYTE_W-1:0]  byte_o
);
  always_comb begin
    byte_o = '0;
    if (idx_i < IDX_W'(TAG_LEN)) begin
      byte_o = tag_byte(kind_i, idx_i[2:0]);
    end else if (kind_i == KIND_FRAME) begin
      byte_o = (idx_i == IDX_W'(TAG_LEN)) ? fld_i.fnum[7:0] : fld_i.fnum[15:8];
    end else begin
      case (idx_i)
        IDX_W'(TAG_LEN + 0): byte_o = fld_i.width[7:0];
        IDX_W'(TAG_LEN + 1): byte_o = fld_i.width[15:8];
        IDX_W'(TAG_LEN + 2): byte_o = fld_i.height[7:0];
        IDX_W'(TAG_LEN + 3): byte_o = fld_i.height[15:8];
        IDX_W'(TAG_LEN + 4): byte_o = fld_i.levels;
        default:             byte_o = fld_i.mode;
      endcase
    end
  end
endmodule

// File: rtl/host_reply_tx.sv
module host_reply_tx
  import host_reply_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              caps_req_i,
  input  logic              frame_req_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [LVL_W-1:0]  levels_m1_i,
  input  logic [FBUF_W-1:0] frames_m1_i,
  input  logic [CHAN_W-1:0] channels_i,
  input  logic [FNUM_W-1:0] frame_num_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  localparam int GW = (N_KIND > 1) ? $clog2(N_KIND) : 1;

  logic [N_KIND-1:0] req_vec;
  logic [N_KIND-1:0] pend_q;
  logic [N_KIND-1:0] done_vec;
  logic              any_pend;
  logic [GW-1:0]     grant;
  logic              busy_q;
  reply_kind_e       kind_q;
  logic [IDX_W-1:0]  idx_q;
  reply_fields_t     fields_q;
  reply_fields_t     fields_now;
  logic              fire;
  logic              pkt_end;
  logic              start;

  always_comb begin
    req_vec             = '0;
    req_vec[KIND_FRAME] = frame_req_i;
    req_vec[KIND_CAPS]  = caps_req_i;
  end

  assign fire    = busy_q & tx_ready_i;
  assign pkt_end = fire && (idx_q == last_index(kind_q));
  assign start   = !busy_q && any_pend;

  always_comb begin
    done_vec = '0;
    if (pkt_end) done_vec[kind_q] = 1'b1;
  end

  always_comb begin
    fields_now.width  = width_i;
    fields_now.height = height_i;
    fields_now.levels = levels_m1_i;
    fields_now.mode   = {frames_m1_i, 2'b00, channels_i};
    fields_now.fnum   = frame_num_i;
  end

  reply_req_latch #(.N(N_KIND)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (req_vec),
    .clr_i  (done_vec),
    .pend_o (pend_q)
  );

  reply_arbiter #(.N(N_KIND)) u_arb (
    .req_i   (pend_q),
    .any_o   (any_pend),
    .grant_o (grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      kind_q   <= KIND_FRAME;
      idx_q    <= '0;
      fields_q <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      kind_q   <= reply_kind_e'(grant);
      idx_q    <= '0;
      fields_q <= fields_now;
    end else if (fire) begin
      if (pkt_end) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  reply_byte_gen u_gen (
    .kind_i (kind_q),
    .idx_i  (idx_q),
    .fld_i  (fields_q),
    .byte_o (tx_data_o)
  );

  assign tx_valid_o = busy_q;
endmodule

// File: rtl/host_reply_tx_chk.sv
module host_reply_tx_chk
  import host_reply_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              caps_req,
  input logic              frame_req,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [CHAN_W-1:0] channels,
  input logic              busy,
  input reply_kind_e       kind,
  input logic [IDX_W-1:0]  idx,
  input logic [N_KIND-1:0] pend
);
  logic [IDX_W-1:0] final_idx;
  assign final_idx = (kind == KIND_CAPS) ? IDX_W'(CAPS_LEN - 1) : IDX_W'(FRM_LEN - 1);

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R8
  kind_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(tx_ready && idx == final_idx) |=> busy && $stable(kind));

  // R8
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx <= final_idx);

  // R7
  frame_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && pend[KIND_FRAME] && pend[KIND_CAPS] |=> busy && kind == KIND_FRAME);

  // R6
  caps_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    caps_req && !(busy && kind == KIND_CAPS) |=> pend[KIND_CAPS]);

  // R6
  frame_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req && !(busy && kind == KIND_FRAME) |=> pend[KIND_FRAME]);

  // R11
  legal_channels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && pend[KIND_CAPS] && !pend[KIND_FRAME] |-> channels == 2'd1 || channels == 2'd3);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && pend == '0 |=> !tx_valid);
endmodule

bind host_reply_tx host_reply_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .caps_req  (caps_req_i),
  .frame_req (frame_req_i),
  .tx_data   (tx_data_o),
  .tx_valid  (tx_valid_o),
  .tx_ready  (tx_ready_i),
  .channels  (channels_i),
  .busy      (busy_q),
  .kind      (kind_q),
  .idx       (idx_q),
  .pend      (pend_q)
);

// File: tb/host_reply_tx_test.sv
module host_reply_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic caps_req_i = 1'b0, frame_req_i = 1'b0;
  logic [15:0] width_i = '0, height_i = '0, frame_num_i = '0;
  logic [7:0]  levels_m1_i = '0;
  logic [3:0]  frames_m1_i = '0;
  logic [1:0]  channels_i = 2'd1;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_q [14];
  int exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reply_tx uut (
    .clk(clk), .rst_n(rst_n), .caps_req_i(caps_req_i), .frame_req_i(frame_req_i),
    .width_i(width_i), .height_i(height_i), .levels_m1_i(levels_m1_i),
    .frames_m1_i(frames_m1_i), .channels_i(channels_i), .frame_num_i(frame_num_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_tag(bit caps);
    logic [7:0] t [8];
    t = '{8'h44, 8'h49, 8'h53, 8'h50, 8'h5F, 8'h00, 8'h00, 8'h00};
    if (caps) begin t[5] = 8'h53; t[6] = 8'h45; t[7] = 8'h54; end
    else      begin t[5] = 8'h46; t[6] = 8'h52; t[7] = 8'h4D; end
    for (int i = 0; i < 8; i++) exp_q[i] = t[i];
  endtask

  task automatic build_caps(logic [15:0] w, logic [15:0] h, logic [7:0] lv,
                            logic [3:0] fb, logic [1:0] ch);
    set_tag(1);
    exp_q[8]  = w[7:0];  exp_q[9]  = w[15:8];
    exp_q[10] = h[7:0];  exp_q[11] = h[15:8];
    exp_q[12] = lv;
    exp_q[13] = {fb, 2'b00, ch};
    exp_n = 14;
  endtask

  task automatic build_frame(logic [15:0] fn);
    set_tag(0);
    exp_q[8] = fn[7:0]; exp_q[9] = fn[15:8];
    exp_n = 10;
  endtask

  task automatic set_caps_inputs(logic [15:0] w, logic [15:0] h, logic [7:0] lv,
                                 logic [3:0] fb, logic [1:0] ch);
    width_i = w; height_i = h; levels_m1_i = lv; frames_m1_i = fb; channels_i = ch;
  endtask

  task automatic pulse(bit caps, bit frm);
    @(negedge clk);
    caps_req_i = caps; frame_req_i = frm;
    @(negedge clk);
    caps_req_i = 1'b0; frame_req_i = 1'b0;
  endtask

  // receive exp_n bytes and compare; stall toggles ready to exercise back-pressure
  task automatic collect(bit stall, string req);
    int got = 0, guard = 0;
    bit holding = 0;
    logic [7:0] held = '0;
    while (got < exp_n && guard < 400) begin
      @(negedge clk);
      guard++;
      if (holding) begin
        chk(tx_valid_o && tx_data_o == held, "R9 byte held under stall",
            {23'd0, tx_valid_o, tx_data_o}, {24'd1, held});
        holding = 0;
      end
      tx_ready_i = stall ? (guard % 3 != 0) : 1'b1;
      if (tx_valid_o && tx_ready_i) begin
        chk(tx_data_o == exp_q[got], $sformatf("%s byte %0d", req, got), tx_data_o, exp_q[got]);
        got++;
      end else if (tx_valid_o) begin
        holding = 1; held = tx_data_o;
      end
    end
    chk(got == exp_n, {req, " packet length"}, got, exp_n);
    @(negedge clk);
    tx_ready_i = 1'b0;
  endtask

  task automatic quiet(int n, string req);
    bit seen = 0;
    tx_ready_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_valid_o) seen = 1;
    end
    tx_ready_i = 1'b0;
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset;
    // R1
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!tx_valid_o, "R1 idle after reset", tx_valid_o, 0);
    end
  endtask

  task automatic t_caps_rgb;
    set_caps_inputs(16'd800, 16'd480, 8'hFF, 4'hF, 2'd3);
    build_caps(16'd800, 16'd480, 8'hFF, 4'hF, 2'd3);
    @(negedge clk);
    caps_req_i = 1'b1;
    @(negedge clk);
    caps_req_i = 1'b0;
    chk(!tx_valid_o, "R12 valid not yet after one edge", tx_valid_o, 0);
    @(negedge clk);
    chk(tx_valid_o, "R12 valid after second edge", tx_valid_o, 1);
    collect(0, "R2 R3 R4 R11 caps rgb");
  endtask

  task automatic t_caps_mono;
    set_caps_inputs(16'h1234, 16'hABCD, 8'h01, 4'h0, 2'd1);
    build_caps(16'h1234, 16'hABCD, 8'h01, 4'h0, 2'd1);
    pulse(1, 0);
    collect(1, "R3 R4 R11 caps mono stalled");
  endtask

  task automatic t_frame;
    frame_num_i = 16'hBEEF;
    build_frame(16'hBEEF);
    pulse(0, 1);
    collect(1, "R5 frame stalled");
  endtask

  task automatic t_both;
    set_caps_inputs(16'd320, 16'd240, 8'h02, 4'h3, 2'd1);
    frame_num_i = 16'h0102;
    pulse(1, 1);
    build_frame(16'h0102);
    collect(0, "R7 frame first");
    build_caps(16'd320, 16'd240, 8'h02, 4'h3, 2'd1);
    collect(0, "R7 caps second");
    quiet(20, "R7 nothing after pair");
  endtask

  task automatic t_merge;
    set_caps_inputs(16'd64, 16'd32, 8'h0F, 4'h1, 2'd3);
    build_caps(16'd64, 16'd32, 8'h0F, 4'h1, 2'd3);
    pulse(1, 0);
    pulse(1, 0);
    pulse(1, 0);
    collect(0, "R6 merged caps");
    quiet(20, "R6 no second caps packet");
    frame_num_i = 16'h0042;
    build_frame(16'h0042);
    pulse(0, 1);
    pulse(0, 1);
    collect(0, "R6 merged frame");
    quiet(20, "R6 no second frame packet");
  endtask

  task automatic t_snapshot;
    frame_num_i = 16'h1111;
    build_frame(16'h1111);
    pulse(0, 1);
    @(negedge clk);
    frame_num_i = 16'h2222;
    collect(1, "R10 frame fields captured");
    set_caps_inputs(16'h0A0B, 16'h0C0D, 8'h07, 4'h2, 2'd3);
    build_caps(16'h0A0B, 16'h0C0D, 8'h07, 4'h2, 2'd3);
    pulse(1, 0);
    @(negedge clk);
    set_caps_inputs(16'hFFFF, 16'hFFFF, 8'h00, 4'hF, 2'd1);
    collect(1, "R10 caps fields captured");
  endtask

  task automatic t_no_interrupt;
    set_caps_inputs(16'd128, 16'd64, 8'h03, 4'h7, 2'd1);
    frame_num_i = 16'h5A5A;
    pulse(1, 0);
    pulse(0, 1);
    build_caps(16'd128, 16'd64, 8'h03, 4'h7, 2'd1);
    collect(1, "R8 started caps completes");
    build_frame(16'h5A5A);
    collect(0, "R8 waiting frame follows");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_caps_rgb();
    t_caps_mono();
    t_frame();
    t_both();
    t_merge();
    t_snapshot();
    t_no_interrupt();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule